// File: doc/BRIEF.md
# Register-Array Sorting Engine

This block sorts a set of unsigned values that is kept entirely in flip-flops. A start pulse opens a loading window. Values then arrive one at a time on a valid/data pair and shift into a chain of slot registers. Once the whole set is present, every neighbouring pair of slots runs a compare-and-exchange step in the same cycle. The pairs in use alternate between two groupings, one offset by a slot from the other, on successive cycles. A set of SLOTS values is therefore in order after SLOTS such cycles.

After sorting, the set leaves through the same chain, one value per cycle, smallest first. The result is read from the head slot as the chain moves, so no wide selector over all slots is needed. A one-cycle completion pulse marks the end of sorting and the first output beat. Set size and value width are parameters; the defaults are 48 slots of 16 bits.

Top module: `oets_sorter`

## Requirements
- R1: While reset is held and in the cycle after it is released, `done` and `out_valid` are 0 and `out_data` is 0.
- R2: A `start` pulse while idle opens loading. During loading a value is taken only on cycles with `ld_valid` high, and cycles with `ld_valid` low may fall between them. Loading closes after exactly SLOTS values.
- R3: `ld_valid` and `ld_data` have no effect outside the loading window, whether idle, sorting or unloading, and they never alter the sorted result.
- R4: `done` is high for exactly one cycle. It rises SLOTS clock edges after the edge that captured the last loaded value.
- R5: `out_valid` is high for exactly SLOTS consecutive cycles and is never high at any other time. The first of these cycles is the cycle in which `done` is high.
- R6: The values on `out_data` during the `out_valid` beats are the loaded values in ascending unsigned order, smallest first, with every value present as often as it was loaded.
- R7: A `start` pulse while loading, sorting or unloading is ignored. It neither restarts the block nor changes the timing or the result.
- R8: Sets with repeated values, including a set of SLOTS equal values, come out with every repeat present. After the last beat the block is idle and accepts a new `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | A load value is present |
| ld_data | input | WIDTH | Value to load |
| start | input | 1 | Opens a new load window when idle |
| done | output | 1 | One-cycle pulse when sorting completes |
| out_valid | output | 1 | A sorted value is on `out_data` |
| out_data | output | WIDTH | Sorted value, smallest first |

## Verification
All results are tied to the clock edge that captures the last load value. The edges after it are counted, so `done` must read 0 after edges 1 to SLOTS-1 and 1 after edge SLOTS. That same sample also carries the first output beat, and each later output beat is due exactly one edge after the one before. `out_valid` must fall one edge after the last beat. The bench drives on falling edges and samples each expected cycle there. A late or early result is therefore a mismatch and is never waited out. Stray `start` and `ld_valid` pulses are placed inside known cycles of sorting and unloading, and the same per-cycle schedule then proves that they changed nothing.

// File: rtl/oets_pkg.sv
package oets_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_SORT   = 2'd2,
        ST_UNLOAD = 2'd3
    } oets_state_e;

endpackage

// File: rtl/oets_cmp_swap.sv
module oets_cmp_swap #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] lo,
    output logic [WIDTH-1:0] hi
);
    logic swap;

    // equal values keep their positions: exchange only on strict inversion
    always_comb begin
        swap = (b < a);
        lo   = swap ? b : a;
        hi   = swap ? a : b;
    end
endmodule

// File: rtl/oets_ctrl.sv
module oets_ctrl
    import oets_pkg::*;
#(
    parameter int SLOTS = 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        ld_valid,
    output oets_state_e state,
    output logic        shift_en,
    output logic        sort_en,
    output logic        phase_odd,
    output logic        done
);
    localparam int CW = (SLOTS > 2) ? $clog2(SLOTS) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

    typedef struct packed {
        oets_state_e   st;
        logic [CW-1:0] cnt;
        logic          done;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        unique case (ctrl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctrl_d.st  = ST_LOAD;
                    ctrl_d.cnt = '0;
                end
            end
            ST_LOAD: begin
                if (ld_valid) begin
                    if (ctrl_q.cnt == LAST) begin
                        ctrl_d.st  = ST_SORT;
                        ctrl_d.cnt = '0;
                    end else begin
                        ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                    end
                end
            end
            ST_SORT: begin
                if (ctrl_q.cnt == LAST) begin
                    ctrl_d.st   = ST_UNLOAD;
                    ctrl_d.cnt  = '0;
                    ctrl_d.done = 1'b1;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            ST_UNLOAD: begin
                if (ctrl_q.cnt == LAST) begin
                    ctrl_d.st  = ST_IDLE;
                    ctrl_d.cnt = '0;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{st: ST_IDLE, cnt: '0, done: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        state     = ctrl_q.st;
        shift_en  = ((ctrl_q.st == ST_LOAD) && ld_valid) || (ctrl_q.st == ST_UNLOAD);
        sort_en   = (ctrl_q.st == ST_SORT);
        phase_odd = ctrl_q.cnt[0];
        done      = ctrl_q.done;
    end

    // R4: completion pulse lasts one cycle
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.done |=> !ctrl_q.done);

    // R7: once sorting, only sorting or unloading may follow
    a_r7_sort_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == ST_SORT) |=> (ctrl_q.st == ST_SORT || ctrl_q.st == ST_UNLOAD));

    // R2: the phase/load counter never passes the last slot
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.cnt <= LAST);

    // R5: the final unload beat returns the block to idle
    a_r5_unload_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == ST_UNLOAD && ctrl_q.cnt == LAST) |=> (ctrl_q.st == ST_IDLE));
endmodule

// File: rtl/oets_regbank.sv
module oets_regbank #(
    parameter int SLOTS = 48,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic [WIDTH-1:0] shift_in,
    input  logic             sort_en,
    input  logic             phase_odd,
    output logic [WIDTH-1:0] head
);
    localparam int PAIRS = SLOTS - 1;

    typedef struct packed {
        logic [SLOTS-1:0][WIDTH-1:0] slot;
    } bank_t;

    bank_t bank_d, bank_q;

    logic [WIDTH-1:0] lo_w  [PAIRS];
    logic [WIDTH-1:0] hi_w  [PAIRS];
    logic [WIDTH-1:0] ev_val[SLOTS];
    logic [WIDTH-1:0] od_val[SLOTS];

    // one compare-exchange element per neighbour pair (p, p+1)
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        oets_cmp_swap #(.WIDTH(WIDTH)) i_cmp (
            .a  (bank_q.slot[p]),
            .b  (bank_q.slot[p+1]),
            .lo (lo_w[p]),
            .hi (hi_w[p])
        );
    end

    // per slot: result in the even grouping (0,1)(2,3).. and the odd one (1,2)(3,4)..
    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
        localparam bit EV_LO = ((j % 2) == 0) && (j + 1 < SLOTS);
        localparam bit EV_HI = ((j % 2) == 1);
        localparam bit OD_LO = ((j % 2) == 1) && (j + 1 < SLOTS);
        localparam bit OD_HI = ((j % 2) == 0) && (j >= 1);
        if (EV_LO) begin : g_ev_lo
            assign ev_val[j] = lo_w[j];
        end else if (EV_HI) begin : g_ev_hi
            assign ev_val[j] = hi_w[j-1];
        end else begin : g_ev_keep
            assign ev_val[j] = bank_q.slot[j];
        end
        if (OD_LO) begin : g_od_lo
            assign od_val[j] = lo_w[j];
        end else if (OD_HI) begin : g_od_hi
            assign od_val[j] = hi_w[j-1];
        end else begin : g_od_keep
            assign od_val[j] = bank_q.slot[j];
        end
    end

    always_comb begin
        bank_d = bank_q;
        if (shift_en) begin
            for (int j = 0; j < SLOTS - 1; j++) begin
                bank_d.slot[j] = bank_q.slot[j+1];
            end
            bank_d.slot[SLOTS-1] = shift_in;
        end else if (sort_en) begin
            for (int j = 0; j < SLOTS; j++) begin
                bank_d.slot[j] = phase_odd ? od_val[j] : ev_val[j];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign head = bank_q.slot[0];

    // R6: after an even-grouping step the two lowest slots are in order
    a_r6_pair_ordered: assert property (@(posedge clk) disable iff (!rst_n)
        (sort_en && !phase_odd && !shift_en) |=> (bank_q.slot[0] <= bank_q.slot[1]));
endmodule

// File: rtl/oets_sorter.sv
module oets_sorter
    import oets_pkg::*;
#(
    parameter int SLOTS = 48,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_valid,
    input  logic [WIDTH-1:0] ld_data,
    input  logic             start,
    output logic             done,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data
);
    oets_state_e      state;
    logic             shift_en;
    logic             sort_en;
    logic             phase_odd;
    logic [WIDTH-1:0] shift_in;
    logic [WIDTH-1:0] head;

    oets_ctrl #(.SLOTS(SLOTS)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ld_valid  (ld_valid),
        .state     (state),
        .shift_en  (shift_en),
        .sort_en   (sort_en),
        .phase_odd (phase_odd),
        .done      (done)
    );

    // unload drains the chain and backfills zeros; load feeds the tail
    assign shift_in = (state == ST_LOAD) ? ld_data : '0;

    oets_regbank #(.SLOTS(SLOTS), .WIDTH(WIDTH)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .shift_in  (shift_in),
        .sort_en   (sort_en),
        .phase_odd (phase_odd),
        .head      (head)
    );

    assign out_valid = (state == ST_UNLOAD);
    assign out_data  = head;

    // R5: the output burst opens together with the completion pulse
    a_r5_valid_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> done);

    // R6: successive output beats never decrease
    a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> ($past(out_data) <= out_data));
endmodule

// File: tb/test_oets_sorter.sv
module test_oets_sorter;
    localparam int N  = 48;
    localparam int W  = 16;
    localparam int NT = 7;

    // test table: pattern kind, seed, flags {junk, poke_start, gaps}
    // kind 0 random, 1 ascending, 2 descending, 3 all equal, 4 few distinct, 5 extremes
    localparam int          T_KIND [NT] = '{0, 1, 2, 3, 4, 5, 0};
    localparam int unsigned T_SEED [NT] = '{32'h1234_5678, 32'd7, 32'd900, 32'h0000_5A5A,
                                            32'hCAFE_0001, 32'h0BAD_F00D, 32'h9E37_79B9};
    localparam logic [2:0]  T_FLAG [NT] = '{3'b000, 3'b000, 3'b001, 3'b000, 3'b011, 3'b100, 3'b111};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld_valid = 1'b0;
    logic [W-1:0] ld_data = '0;
    logic         start = 1'b0;
    logic         done;
    logic         out_valid;
    logic [W-1:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic [W-1:0] vin [N];
    logic [W-1:0] vexp[N];

    always #10 clk = ~clk;

    oets_sorter #(.SLOTS(N), .WIDTH(W)) i_oets_sorter (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ld_data   (ld_data),
        .start     (start),
        .done      (done),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [31:0] xs32(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic build_set(input int kind, input logic [31:0] seed);
        logic [31:0] st;
        logic [W-1:0] t;
        st = (seed == 0) ? 32'h1 : seed;
        for (int k = 0; k < N; k++) begin
            st = xs32(st);
            case (kind)
                1:       vin[k] = W'(seed) + W'(k * 3);
                2:       vin[k] = W'(60000 - k * 5);
                3:       vin[k] = W'(seed);
                4:       vin[k] = W'(st[1:0]) + W'(100);
                5:       vin[k] = (k % 3 == 0) ? '0 : (k % 3 == 1) ? '1 : st[W-1:0];
                default: vin[k] = st[W-1:0];
            endcase
        end
        for (int k = 0; k < N; k++) vexp[k] = vin[k];
        for (int i = 1; i < N; i++) begin
            for (int j = i; j > 0; j--) begin
                if (vexp[j-1] > vexp[j]) begin
                    t = vexp[j]; vexp[j] = vexp[j-1]; vexp[j-1] = t;
                end
            end
        end
    endtask

    task automatic run_set(input int tno, input int kind, input logic [31:0] seed, input logic [2:0] fl);
        bit gaps, poke, junk, tim_ok, beat_ok;
        gaps = fl[0]; poke = fl[1]; junk = fl[2];
        build_set(kind, seed);
        @(negedge clk);
        chk("R8 idle before set", {30'd0, done, out_valid}, 32'd0);
        if (junk) begin
            // R3: values offered while idle must not enter the set
            ld_valid = 1'b1; ld_data = 16'hDEAD;
            @(negedge clk);
            ld_data = 16'h0001;
            @(negedge clk);
            ld_valid = 1'b0;
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (gaps && (k % 5 == 2)) begin
                ld_valid = 1'b0; ld_data = 16'hBEEF;
                @(negedge clk);
            end
            ld_valid = 1'b1; ld_data = vin[k];
            start = poke && (k == 10); // R7 stray start while loading
            @(negedge clk);
        end
        start = 1'b0;
        ld_valid = junk; ld_data = 16'h0002; // R3 stray loads while sorting
        tim_ok = 1'b1;
        for (int c = 1; c <= N; c++) begin
            @(negedge clk);
            start = poke && (c == 5);         // R7 stray start while sorting
            if (c < N && (done !== 1'b0 || out_valid !== 1'b0)) tim_ok = 1'b0;
        end
        chk("R4 done low during sort", {31'd0, tim_ok}, 32'd1);
        chk("R4 done at edge N", {31'd0, done}, 32'd1);
        chk("R5 valid with done", {31'd0, out_valid}, 32'd1);
        chk("R6 first beat", {16'd0, out_data}, {16'd0, vexp[0]});
        beat_ok = 1'b1;
        for (int k = 1; k < N; k++) begin
            start = poke && (k == 3);         // R7 stray start while unloading
            @(negedge clk);
            chk("R6 sorted beat", {16'd0, out_data}, {16'd0, vexp[k]});
            if (out_valid !== 1'b1 || done !== 1'b0) beat_ok = 1'b0;
        end
        start = 1'b0;
        chk("R5 valid held, R4 done single", {31'd0, beat_ok}, 32'd1);
        @(negedge clk);
        ld_valid = 1'b0;
        chk("R5 valid falls after N beats", {31'd0, out_valid}, 32'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8 idle after set", {30'd0, done, out_valid}, 32'd0);
        end
        if (tno < 0) $display("unused");
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                report();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 done in reset", {31'd0, done}, 32'd0);
        chk("R1 valid in reset", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {15'd0, done, out_valid, out_data}, 32'd0);
        // R2 R3 R6 R7 R8 through the table
        for (int t = 0; t < NT; t++) begin
            run_set(t, T_KIND[t], T_SEED[t], T_FLAG[t]);
        end
        // R7: start during unload of a prior set left the block idle, not loading
        ld_valid = 1'b1; ld_data = 16'h7777;
        repeat (N + 2) @(negedge clk);
        ld_valid = 1'b0;
        repeat (N + 2) begin
            @(negedge clk);
            chk("R3 R7 no run without start", {30'd0, done, out_valid}, 32'd0);
        end
        report();
    end
endmodule